// File: doc/BRIEF.md
# Thermometer Function-Command and Scratchpad Unit

This block is the function layer of a single-wire thermometer slave. It comes into play once the ROM layer has picked this slave. It takes an 8-bit function command from the bit-level interface, least significant bit first. It then runs one of six operations:

- start a temperature conversion;
- write the two alarm-limit bytes;
- stream out the 9-byte scratchpad;
- copy the limits into a nonvolatile store;
- recall the limits from that store;
- report how the slave is powered.

The sensor, the analog front end and the nonvolatile cells are stand-ins. A conversion-engine stub presents a 16-bit result and a remaining-count byte. The unit captures both when its conversion timer expires. Three busy timers, counted in clock cycles, model conversion, copy and recall. While one of them runs, the read slots answer busy or done. After each conversion the unit compares the new temperature against the upper and lower limits and updates its alarm flag. A strong-pullup request is raised while a conversion or a copy runs on a parasite-powered slave.

The bit-level layer drives the inputs of this block:
- `sel_i` marks the start of the function phase.
- `bus_rst_i` signals a bus reset, which ends any transfer.
- `wr_valid_i` and `wr_bit_i` carry one master write slot.
- `rd_slot_i` marks one master read slot. `rd_bit_o` is the bit the slave returns in that slot.

Top module: `thermo_fn_unit`

## Requirements
- R1: After the 8 bits of a command (LSB first), the unit acts on 0x44 (convert), 0x4E (write limits), 0xBE (read scratchpad), 0x48 (copy), 0xB8 (recall) and 0xB4 (power query). Any other code is ignored: every later read slot returns 1 and no stored byte changes.
- R2: A read returns 72 bits, LSB first, starting at byte 0:
  - bytes 0 and 1: temperature low and high byte;
  - byte 2: upper limit;
  - byte 3: lower limit;
  - bytes 4 and 5: 0xFF;
  - byte 6: remaining count;
  - byte 7: 0x10.

  Read slots after the 72nd return 1.
- R3: Byte 8 is the CRC of bytes 0 to 7 under x^8+x^5+x^4+1. The register starts at zero and the data is fed LSB first, so the 72 bits read back shift to a zero residue.
- R4: Write-limits takes two bytes, LSB first. The first byte becomes the upper limit and the second the lower limit. Bytes 0, 1 and 6 are not affected.
- R5: A bus reset ends any transfer at once; the next read slot returns 1. A new read command starts again at bit 0 of byte 0.
- R6: After a convert command, read slots return 0 for exactly CONV_CYCLES cycles and then 1. The stub's temperature and remaining count appear in bytes 0, 1 and 6 once the slots return 1.
- R7: When a conversion ends, the alarm flag is set if signed temperature bits 8:1 are above the upper limit or below the lower limit. Equality with either limit does not set it. The flag changes at no other time.
- R8: After a copy command, read slots return 0 for exactly COPY_CYCLES cycles and then 1. The nonvolatile store then holds the scratchpad limits.
- R9: After a recall command, read slots return 0 for exactly RECALL_CYCLES cycles and then 1. The scratchpad limits then equal the nonvolatile store.
- R10: After reset, the scratchpad holds TEMP_INIT, REMAIN_INIT and the nonvolatile defaults NV_TH_INIT and NV_TL_INIT as limits. The alarm is clear and the strong-pullup request is low.
- R11: In the read slot after a power query, a parasite-powered slave returns 0 and an externally powered slave returns 1.
- R12: The strong-pullup request is high only in parasite mode, and exactly while a conversion or copy is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| sel_i | input | 1 | Pulse: slave selected, function command follows |
| bus_rst_i | input | 1 | Pulse: bus reset seen, abort transfer |
| wr_valid_i | input | 1 | Pulse: one master write slot |
| wr_bit_i | input | 1 | Bit value of the write slot |
| rd_slot_i | input | 1 | Pulse: one master read slot |
| rd_bit_o | output | 1 | Bit the slave returns in the current read slot |
| parasite_i | input | 1 | 1 when the slave is parasite powered |
| conv_temp_i | input | 16 | Conversion stub temperature, 0.5 degree per LSB |
| conv_remain_i | input | 8 | Conversion stub remaining count |
| spu_o | output | 1 | Strong-pullup request |
| alarm_o | output | 1 | Alarm flag |

## Verification
Two things are hard to reach from the ports. The first is the exact width of each busy window. The bench counts zero-valued status slots in back-to-back read slots, from the slot just after the command's last write bit, and expects exactly the parameter count. The second is the alarm compare at equality and one step past it, for both signs. The bench reaches these cases by writing limits through the write-limits command and then running a conversion for each chosen stub value. A copy, an overwrite and then a recall expose the hidden nonvolatile store.

// File: rtl/thermo_fn_pkg.sv
package thermo_fn_pkg;

  localparam int SP_BITS = 72;
  localparam int NUM_OPS = 3;
  localparam int OP_CONV = 0;
  localparam int OP_COPY = 1;
  localparam int OP_RECALL = 2;

  typedef enum logic [7:0] {
    CMD_CONVERT = 8'h44,
    CMD_WR_LIM  = 8'h4E,
    CMD_RD_SP   = 8'hBE,
    CMD_COPY    = 8'h48,
    CMD_RECALL  = 8'hB8,
    CMD_PWR     = 8'hB4
  } fn_cmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_WRITE, S_READ, S_STAT, S_PWR, S_DONE
  } seq_state_e;

  // Reflected form of x^8+x^5+x^4+1, data LSB first, register starts at 0.
  function automatic logic [7:0] crc8_lsb_first(input logic [63:0] data);
    logic [7:0] c;
    logic fb;
    c = '0;
    for (int i = 0; i < 64; i++) begin
      fb = c[0] ^ data[i];
      c  = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  // Window compare on temperature bits 8:1 against signed limits.
  function automatic logic alarm_hit(input logic [15:0] temp,
                                     input logic [7:0] hi,
                                     input logic [7:0] lo);
    logic signed [7:0] t;
    t = signed'(temp[8:1]);
    return (t > signed'(hi)) || (t < signed'(lo));
  endfunction

  function automatic logic [SP_BITS-1:0] pack_scratch(input logic [15:0] temp,
                                                      input logic [7:0] th,
                                                      input logic [7:0] tl,
                                                      input logic [7:0] remain);
    logic [63:0] body;
    body = {8'h10, remain, 8'hFF, 8'hFF, tl, th, temp[15:8], temp[7:0]};
    return {crc8_lsb_first(body), body};
  endfunction

endpackage

// File: rtl/thermo_busy_timer.sv
module thermo_busy_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  // A start while already busy is ignored.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  // Independent length counter for the busy window.
  logic [CW:0] len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (busy_q) len_q <= len_q + 1'b1;
    else             len_q <= '0;
  end

  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (len_q == (CW+1)'(CYCLES - 1)))
    else $error("busy window length differs from CYCLES");

endmodule

// File: rtl/thermo_scratch.sv
module thermo_scratch
  import thermo_fn_pkg::*;
#(
  parameter logic [15:0] TEMP_INIT   = 16'h00AA,
  parameter logic [7:0]  REMAIN_INIT = 8'h0C,
  parameter logic [7:0]  NV_TH_INIT  = 8'h4B,
  parameter logic [7:0]  NV_TL_INIT  = 8'hF6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_th_en_i,
  input  logic               wr_tl_en_i,
  input  logic [7:0]         wr_byte_i,
  input  logic [NUM_OPS-1:0] op_done_i,
  input  logic [15:0]        conv_temp_i,
  input  logic [7:0]         conv_remain_i,
  output logic [SP_BITS-1:0] sp_vec_o,
  output logic               alarm_o
);
  logic [15:0] temp_q;
  logic [7:0]  remain_q, th_q, tl_q, nv_th_q, nv_tl_q;
  logic        alarm_q;

  wire conv_done_w   = op_done_i[OP_CONV];
  wire copy_done_w   = op_done_i[OP_COPY];
  wire recall_done_w = op_done_i[OP_RECALL];

  // Conversion result and alarm flag.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_q   <= TEMP_INIT;
      remain_q <= REMAIN_INIT;
      alarm_q  <= 1'b0;
    end else if (conv_done_w) begin
      temp_q   <= conv_temp_i;
      remain_q <= conv_remain_i;
      alarm_q  <= alarm_hit(conv_temp_i, th_q, tl_q);
    end
  end

  // Limits: written by command, overwritten by a finished recall.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      th_q <= NV_TH_INIT;
      tl_q <= NV_TL_INIT;
    end else if (recall_done_w) begin
      th_q <= nv_th_q;
      tl_q <= nv_tl_q;
    end else begin
      if (wr_th_en_i) th_q <= wr_byte_i;
      if (wr_tl_en_i) tl_q <= wr_byte_i;
    end
  end

  // Nonvolatile store model.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_th_q <= NV_TH_INIT;
      nv_tl_q <= NV_TL_INIT;
    end else if (copy_done_w) begin
      nv_th_q <= th_q;
      nv_tl_q <= tl_q;
    end
  end

  assign sp_vec_o = pack_scratch(temp_q, th_q, tl_q, remain_q);
  assign alarm_o  = alarm_q;

  p_temp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done_w |=> $stable(temp_q))
    else $error("temperature changed without conversion end");

  p_alarm_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done_w |=> $stable(alarm_q))
    else $error("alarm changed without conversion end");

  p_nv_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !copy_done_w |=> ($stable(nv_th_q) && $stable(nv_tl_q)))
    else $error("nonvolatile store changed without copy end");

  p_th_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_th_en_i && !recall_done_w) |=> $stable(th_q))
    else $error("upper limit changed without write or recall");

endmodule

// File: rtl/thermo_fn_seq.sv
module thermo_fn_seq
  import thermo_fn_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_i,
  input  logic               bus_rst_i,
  input  logic               wr_valid_i,
  input  logic               wr_bit_i,
  input  logic               rd_slot_i,
  input  logic               parasite_i,
  input  logic [NUM_OPS-1:0] op_busy_i,
  input  logic [SP_BITS-1:0] sp_vec_i,
  output logic               rd_bit_o,
  output logic [NUM_OPS-1:0] op_start_o,
  output logic               wr_th_en_o,
  output logic               wr_tl_en_o,
  output logic [7:0]         wr_byte_o
);
  localparam int PW = $clog2(SP_BITS);

  seq_state_e    st_q;
  logic [3:0]    cnt_q;
  logic [7:0]    shreg_q;
  logic [PW-1:0] rd_ptr_q;
  logic [1:0]    stat_sel_q;

  logic [7:0] byte_nxt;
  logic       cmd_done, wr_bit_ev;

  assign byte_nxt  = {wr_bit_i, shreg_q[7:1]};
  assign wr_bit_ev = wr_valid_i && !bus_rst_i;
  assign cmd_done  = (st_q == S_CMD) && wr_bit_ev && (cnt_q[2:0] == 3'd7);

  always_comb begin
    op_start_o = '0;
    op_start_o[OP_CONV]   = cmd_done && (byte_nxt == CMD_CONVERT);
    op_start_o[OP_COPY]   = cmd_done && (byte_nxt == CMD_COPY);
    op_start_o[OP_RECALL] = cmd_done && (byte_nxt == CMD_RECALL);
  end

  assign wr_th_en_o = (st_q == S_WRITE) && wr_bit_ev && (cnt_q == 4'd7);
  assign wr_tl_en_o = (st_q == S_WRITE) && wr_bit_ev && (cnt_q == 4'd15);
  assign wr_byte_o  = byte_nxt;

  always_comb begin
    unique case (st_q)
      S_READ:  rd_bit_o = sp_vec_i[rd_ptr_q];
      S_STAT:  rd_bit_o = !op_busy_i[stat_sel_q];
      S_PWR:   rd_bit_o = !parasite_i;
      default: rd_bit_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      cnt_q      <= '0;
      shreg_q    <= '0;
      rd_ptr_q   <= '0;
      stat_sel_q <= '0;
    end else if (bus_rst_i) begin
      st_q     <= S_IDLE;
      cnt_q    <= '0;
      rd_ptr_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (sel_i) begin
          st_q  <= S_CMD;
          cnt_q <= '0;
        end
        S_CMD: if (wr_valid_i) begin
          shreg_q <= byte_nxt;
          cnt_q   <= cnt_q + 1'b1;
          if (cnt_q[2:0] == 3'd7) begin
            case (byte_nxt)
              CMD_CONVERT: begin st_q <= S_STAT; stat_sel_q <= 2'(OP_CONV);   end
              CMD_COPY:    begin st_q <= S_STAT; stat_sel_q <= 2'(OP_COPY);   end
              CMD_RECALL:  begin st_q <= S_STAT; stat_sel_q <= 2'(OP_RECALL); end
              CMD_WR_LIM:  begin st_q <= S_WRITE; cnt_q <= '0; end
              CMD_RD_SP:   begin st_q <= S_READ; rd_ptr_q <= '0; end
              CMD_PWR:     st_q <= S_PWR;
              default:     st_q <= S_DONE;
            endcase
          end
        end
        S_WRITE: if (wr_valid_i) begin
          shreg_q <= byte_nxt;
          cnt_q   <= cnt_q + 1'b1;
          if (cnt_q == 4'd15) st_q <= S_DONE;
        end
        S_READ: if (rd_slot_i) begin
          if (rd_ptr_q == PW'(SP_BITS - 1)) st_q <= S_DONE;
          else rd_ptr_q <= rd_ptr_q + 1'b1;
        end
        S_PWR: if (rd_slot_i) st_q <= S_DONE;
        default: ;
      endcase
    end
  end

  p_rd_ptr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr_q < PW'(SP_BITS))
    else $error("read pointer out of range");

  p_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_i |=> rd_bit_o)
    else $error("read slot not released after bus reset");

  p_one_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(op_start_o))
    else $error("more than one operation started");

endmodule

// File: rtl/thermo_fn_unit.sv
module thermo_fn_unit
  import thermo_fn_pkg::*;
#(
  parameter int          CONV_CYCLES   = 40,
  parameter int          COPY_CYCLES   = 20,
  parameter int          RECALL_CYCLES = 10,
  parameter logic [15:0] TEMP_INIT     = 16'h00AA,
  parameter logic [7:0]  REMAIN_INIT   = 8'h0C,
  parameter logic [7:0]  NV_TH_INIT    = 8'h4B,
  parameter logic [7:0]  NV_TL_INIT    = 8'hF6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_i,
  input  logic        bus_rst_i,
  input  logic        wr_valid_i,
  input  logic        wr_bit_i,
  input  logic        rd_slot_i,
  output logic        rd_bit_o,
  input  logic        parasite_i,
  input  logic [15:0] conv_temp_i,
  input  logic [7:0]  conv_remain_i,
  output logic        spu_o,
  output logic        alarm_o
);
  logic [NUM_OPS-1:0] op_start, op_busy, op_done;
  logic [SP_BITS-1:0] sp_vec;
  logic               wr_th_en, wr_tl_en;
  logic [7:0]         wr_byte;

  thermo_fn_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_i      (sel_i),
    .bus_rst_i  (bus_rst_i),
    .wr_valid_i (wr_valid_i),
    .wr_bit_i   (wr_bit_i),
    .rd_slot_i  (rd_slot_i),
    .parasite_i (parasite_i),
    .op_busy_i  (op_busy),
    .sp_vec_i   (sp_vec),
    .rd_bit_o   (rd_bit_o),
    .op_start_o (op_start),
    .wr_th_en_o (wr_th_en),
    .wr_tl_en_o (wr_tl_en),
    .wr_byte_o  (wr_byte)
  );

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    localparam int CYC = (g == OP_CONV) ? CONV_CYCLES :
                         (g == OP_COPY) ? COPY_CYCLES : RECALL_CYCLES;
    thermo_busy_timer #(.CYCLES(CYC)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (op_start[g]),
      .busy_o  (op_busy[g]),
      .done_o  (op_done[g])
    );
  end

  thermo_scratch #(
    .TEMP_INIT   (TEMP_INIT),
    .REMAIN_INIT (REMAIN_INIT),
    .NV_TH_INIT  (NV_TH_INIT),
    .NV_TL_INIT  (NV_TL_INIT)
  ) u_sp (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_th_en_i    (wr_th_en),
    .wr_tl_en_i    (wr_tl_en),
    .wr_byte_i     (wr_byte),
    .op_done_i     (op_done),
    .conv_temp_i   (conv_temp_i),
    .conv_remain_i (conv_remain_i),
    .sp_vec_o      (sp_vec),
    .alarm_o       (alarm_o)
  );

  assign spu_o = parasite_i && (op_busy[OP_CONV] || op_busy[OP_COPY]);

  p_spu_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start[OP_CONV] && parasite_i) |=> (spu_o || !parasite_i))
    else $error("strong pullup not raised for parasite conversion");

  p_spu_ext_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !parasite_i |-> !spu_o)
    else $error("strong pullup raised while externally powered");

endmodule

// File: tb/test_thermo_fn_unit.sv
module test_thermo_fn_unit;
  localparam int CLK_PERIOD = 10;
  localparam int CONV   = 40;
  localparam int COPY   = 20;
  localparam int RECALL = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_i = 0, bus_rst_i = 0, wr_valid_i = 0, wr_bit_i = 0, rd_slot_i = 0;
  logic parasite_i = 0;
  logic [15:0] conv_temp_i = '0;
  logic [7:0]  conv_remain_i = '0;
  logic rd_bit_o, spu_o, alarm_o;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermo_fn_unit #(.CONV_CYCLES(CONV), .COPY_CYCLES(COPY), .RECALL_CYCLES(RECALL))
  i_thermo_fn_unit (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .bus_rst_i(bus_rst_i),
    .wr_valid_i(wr_valid_i), .wr_bit_i(wr_bit_i), .rd_slot_i(rd_slot_i),
    .rd_bit_o(rd_bit_o), .parasite_i(parasite_i), .conv_temp_i(conv_temp_i),
    .conv_remain_i(conv_remain_i), .spu_o(spu_o), .alarm_o(alarm_o)
  );

  task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Shift-register CRC, taps written out bit by bit.
  function automatic logic [7:0] ref_crc(input logic [71:0] v, input int nbits);
    logic [7:0] s;
    logic x;
    s = 8'h00;
    for (int i = 0; i < nbits; i++) begin
      x = v[i] ^ s[0];
      s = {x, s[7:1]};
      s[3] = s[3] ^ x;
      s[2] = s[2] ^ x;
    end
    return s;
  endfunction

  function automatic logic [71:0] ref_sp(input logic [15:0] t, input logic [7:0] th,
                                         input logic [7:0] tl, input logic [7:0] rem);
    logic [71:0] v;
    v = '0;
    v[7:0] = t[7:0]; v[15:8] = t[15:8]; v[23:16] = th; v[31:24] = tl;
    v[39:32] = 8'hFF; v[47:40] = 8'hFF; v[55:48] = rem; v[63:56] = 8'h10;
    v[71:64] = ref_crc(v, 64);
    return v;
  endfunction

  function automatic logic ref_alarm(input logic [15:0] t, input logic [7:0] th, input logic [7:0] tl);
    int ti, hi, lo;
    ti = int'($signed(t)) >>> 1;
    hi = int'($signed(th));
    lo = int'($signed(tl));
    return (ti > hi) || (ti < lo);
  endfunction

  task automatic bus_reset();
    @(negedge clk); bus_rst_i = 1;
    @(negedge clk); bus_rst_i = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); wr_valid_i = 1; wr_bit_i = b[i];
    end
    @(negedge clk); wr_valid_i = 0;
  endtask

  task automatic begin_cmd(input logic [7:0] c);
    bus_reset();
    @(negedge clk); sel_i = 1;
    @(negedge clk); sel_i = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); wr_valid_i = 1; wr_bit_i = c[i];
    end
  endtask

  task automatic read_bits(input int n, output logic [71:0] v);
    v = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wr_valid_i = 0; rd_slot_i = 1; #1; v[i] = rd_bit_o;
    end
    @(negedge clk); rd_slot_i = 0;
  endtask

  task automatic read_sp(output logic [71:0] v);
    begin_cmd(8'hBE);
    read_bits(72, v);
  endtask

  task automatic write_lim(input logic [7:0] th, input logic [7:0] tl);
    begin_cmd(8'h4E);
    @(negedge clk); wr_valid_i = 0;
    send_byte(th);
    send_byte(tl);
  endtask

  // Back-to-back status slots right after the command; counts zeros until first 1.
  task automatic poll_status(output int zeros, output logic spu_first);
    logic b;
    zeros = 0; spu_first = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); wr_valid_i = 0; rd_slot_i = 1; #1; b = rd_bit_o;
      if (i == 0) spu_first = spu_o;
      if (b) break;
      zeros++;
    end
    @(negedge clk); rd_slot_i = 0;
  endtask

  logic [7:0]  m_th = 8'h4B, m_tl = 8'hF6, m_rem = 8'h0C;
  logic [15:0] m_temp = 16'h00AA;

  task automatic do_convert(input logic [15:0] t, input logic [7:0] r, input string tag);
    int z; logic s;
    conv_temp_i = t; conv_remain_i = r;
    begin_cmd(8'h44);
    poll_status(z, s);
    check({tag, " R6 convert busy slots"}, 72'(z), 72'(CONV));
    check({tag, " R7 alarm"}, 72'(alarm_o), 72'(ref_alarm(t, m_th, m_tl)));
    m_temp = t; m_rem = r;
  endtask

  task automatic t_reset();
    logic [71:0] v;
    check("R10 spu after reset", 72'(spu_o), 72'(0));
    check("R10 alarm after reset", 72'(alarm_o), 72'(0));
    read_sp(v);
    check("R10 R2 reset scratchpad", v, ref_sp(m_temp, m_th, m_tl, m_rem));
    check("R3 crc residue", 72'(ref_crc(v, 72)), 72'(0));
    read_bits(3, v);
    check("R2 slots past end", v[2:0], 72'(3'b111));
  endtask

  task automatic t_write_read();
    logic [71:0] v;
    write_lim(8'h1E, 8'hF6);
    m_th = 8'h1E; m_tl = 8'hF6;
    read_sp(v);
    check("R4 write limits", v, ref_sp(m_temp, m_th, m_tl, m_rem));
    check("R3 crc byte", 72'(v[71:64]), 72'(ref_crc(v, 64)));
  endtask

  task automatic t_convert();
    logic [71:0] v;
    int z; logic s;
    parasite_i = 0;
    conv_temp_i = 16'h0032; conv_remain_i = 8'h05;
    begin_cmd(8'h44);
    poll_status(z, s);
    check("R6 convert busy slots ext", 72'(z), 72'(CONV));
    check("R12 no spu when external", 72'(s), 72'(0));
    m_temp = 16'h0032; m_rem = 8'h05;
    read_sp(v);
    check("R6 result in scratchpad", v, ref_sp(m_temp, m_th, m_tl, m_rem));
    parasite_i = 1;
    conv_temp_i = 16'h0034; conv_remain_i = 8'h07;
    begin_cmd(8'h44);
    poll_status(z, s);
    check("R12 spu during parasite convert", 72'(s), 72'(1));
    check("R12 spu dropped after convert", 72'(spu_o), 72'(0));
    m_temp = 16'h0034; m_rem = 8'h07;
    parasite_i = 0;
  endtask

  task automatic t_alarm();
    do_convert(16'h003C, 8'h01, "equal upper");   // 30 == TH
    do_convert(16'h003E, 8'h02, "above upper");   // 31 > TH
    do_convert(16'hFFEC, 8'h03, "equal lower");   // -10 == TL
    do_convert(16'hFFEA, 8'h04, "below lower");   // -11 < TL
    write_lim(8'h7F, 8'h80);
    check("R7 alarm unchanged by limit write", 72'(alarm_o), 72'(1));
    m_th = 8'h7F; m_tl = 8'h80;
    do_convert(16'h0000, 8'h05, "wide window");
  endtask

  task automatic t_copy_recall();
    logic [71:0] v;
    int z; logic s;
    write_lim(8'h55, 8'h22);
    parasite_i = 1;
    begin_cmd(8'h48);
    poll_status(z, s);
    check("R8 copy busy slots", 72'(z), 72'(COPY));
    check("R12 spu during copy", 72'(s), 72'(1));
    parasite_i = 0;
    write_lim(8'h01, 8'h02);
    m_th = 8'h01; m_tl = 8'h02;
    read_sp(v);
    check("R4 overwrite before recall", v, ref_sp(m_temp, m_th, m_tl, m_rem));
    begin_cmd(8'hB8);
    poll_status(z, s);
    check("R9 recall busy slots", 72'(z), 72'(RECALL));
    check("R12 no spu during recall", 72'(s), 72'(0));
    m_th = 8'h55; m_tl = 8'h22;
    read_sp(v);
    check("R9 R8 recalled limits", v, ref_sp(m_temp, m_th, m_tl, m_rem));
  endtask

  task automatic t_power();
    logic [71:0] v;
    parasite_i = 1;
    begin_cmd(8'hB4);
    read_bits(1, v);
    check("R11 parasite power slot", v[0], 72'(0));
    parasite_i = 0;
    begin_cmd(8'hB4);
    read_bits(1, v);
    check("R11 external power slot", v[0], 72'(1));
  endtask

  task automatic t_abort();
    logic [71:0] v, e;
    e = ref_sp(m_temp, m_th, m_tl, m_rem);
    read_sp_partial: begin
      begin_cmd(8'hBE);
      read_bits(20, v);
      check("R5 partial read", v[19:0], 72'(e[19:0]));
    end
    bus_reset();
    read_bits(1, v);
    check("R5 slot after bus reset", v[0], 72'(1));
    read_sp(v);
    check("R5 read restarts at byte 0", v, e);
  endtask

  task automatic t_unknown();
    logic [71:0] v;
    begin_cmd(8'hAA);
    read_bits(8, v);
    check("R1 unknown command slots", v[7:0], 72'(8'hFF));
    read_sp(v);
    check("R1 unknown command leaves scratchpad", v, ref_sp(m_temp, m_th, m_tl, m_rem));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_convert();
    t_alarm();
    t_copy_recall();
    t_power();
    t_abort();
    t_unknown();
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule